// File: doc/BRIEF.md
# Prescaled Seconds Timebase

This block keeps wall-clock time as a 32-bit count of seconds. A periodic one-cycle strobe from the system timebase drives a 6-bit prescaler. The prescaler's running value is visible in the low bits of a 16-bit status word. When the prescaler is at its all-ones value and another strobe arrives, it wraps to zero and the seconds count advances by one.

Every strobe also produces a one-cycle interrupt request toward the interrupt controller. The host can set the time through a synchronous preset. It reads the count as two 16-bit halves.

A small two-state machine keeps the split read coherent. In state HALF_LIVE, a read of the upper half returns the live count. Reading the lower half takes the machine from HALF_LIVE (or from HALF_HELD) to HALF_HELD and captures the upper half at that moment. A later upper read in HALF_HELD returns the captured half and moves the machine back to HALF_LIVE. A preset also moves the machine back to HALF_LIVE.

Top module: `rtc_timebase`

## Requirements
- R1: Each `tick` strobe increments the prescaler. The prescaler is read as bits [5:0] of the status word, and the status word is read on select 0.
- R2: A `tick` that arrives while the prescaler equals 63 does two things: it clears the prescaler to 0 and adds one to the seconds count. From 0xFFFFFFFF the count wraps to 0. Without a `tick`, the count holds.
- R3: A read on select 1 returns count bits [15:0].
- R4: A read on select 2 returns count bits [31:16]. If a select-1 read came earlier and no select-2 read or preset has come since, it returns the upper half captured at that select-1 read. Otherwise it returns the live upper half.
- R5: `tick_irq` is high for exactly the one cycle after each `tick` cycle and low after any cycle without a `tick`.
- R6: Status bits [15:6] change only through `stat_wr_en`, which loads them from `stat_wr_data[15:6]`. The prescaler never changes them. A status write leaves the prescaler unchanged.
- R7: `preset_en` loads the count from `preset_value` and clears the prescaler, even when a `tick` arrives in the same cycle. It also discards any captured upper half.
- R8: After reset, the count, the prescaler, the status upper bits and `tick_irq` are all zero.
- R9: `rd_data` is zero when `rd_en` is low or when the select is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase strobe |
| preset_en | input | 1 | Load seconds count, clear prescaler |
| preset_value | input | 32 | Value loaded by a preset |
| stat_wr_en | input | 1 | Write status upper bits |
| stat_wr_data | input | 16 | Status write data, bits [15:6] used |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 2 | 0 status, 1 low half, 2 high half, 3 none |
| rd_data | output | 16 | Combinational read data |
| tick_irq | output | 1 | Tick interrupt request pulse |

## Verification
The assertions rely on three properties of the inputs:
- `tick` is a strobe in the clock domain.
- A preset may coincide with a tick, and the preset then wins.
- Reads have no side effect other than the capture of the upper half.

The stimulus drives every input on the falling edge and holds `tick` for one cycle only. It reads the combinational data one time unit after that edge, so each check sees a settled state. The sequences take the prescaler through many full wraps, and they cross 16-bit and 32-bit carries between the two half reads.

// File: rtl/rtc_timebase_pkg.sv
package rtc_timebase_pkg;
    typedef enum logic [1:0] {
        RD_STATUS = 2'd0,
        RD_LOW    = 2'd1,
        RD_HIGH   = 2'd2,
        RD_NONE   = 2'd3
    } rd_sel_e;

    typedef enum logic {
        HALF_LIVE = 1'b0,
        HALF_HELD = 1'b1
    } hold_state_e;
endpackage

// File: rtl/rtc_status_reg.sv
module rtc_status_reg #(
    parameter int PRE_W  = 6,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              preset,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] status,
    output logic              carry
);
    localparam int UP_W = STAT_W - PRE_W;
    localparam logic [PRE_W-1:0] PRE_MAX = '1;

    logic [PRE_W-1:0] presc_q;
    logic [UP_W-1:0]  upper_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            upper_q <= '0;
        end else begin
            if (preset)
                presc_q <= '0;
            else if (tick)
                presc_q <= presc_q + 1'b1;
            if (wr_en)
                upper_q <= wr_data[STAT_W-1:PRE_W];
        end
    end

    assign carry  = tick && !preset && (presc_q == PRE_MAX);
    assign status = {upper_q, presc_q};

    // R1
    presc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !preset) |=> presc_q == PRE_W'($past(presc_q) + 1'b1));
    // R6
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(upper_q));
    // R7
    presc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> presc_q == '0);
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             carry,
    input  logic             preset,
    input  logic [CNT_W-1:0] preset_value,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (preset)
            count_q <= preset_value;
        else if (carry)
            count_q <= count_q + 1'b1;
    end

    assign count = count_q;

    // R2
    sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!carry && !preset) |=> $stable(count_q));
    // R2
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !preset) |=> count_q == CNT_W'($past(count_q) + 1'b1));
    // R7
    sec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> count_q == $past(preset_value));
endmodule

// File: rtl/rtc_readout.sv
module rtc_readout
    import rtc_timebase_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int STAT_W = 16,
    parameter int RD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    input  logic              preset,
    input  logic [CNT_W-1:0]  count,
    input  logic [STAT_W-1:0] status,
    output logic [RD_W-1:0]   rd_data
);
    localparam int HALF_W = CNT_W / 2;

    hold_state_e      state_q, state_d;
    logic [HALF_W-1:0] held_q;
    logic [HALF_W-1:0] upper_view;
    logic              rd_low, rd_high;

    assign rd_low  = rd_en && (rd_sel_e'(rd_sel) == RD_LOW);
    assign rd_high = rd_en && (rd_sel_e'(rd_sel) == RD_HIGH);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HALF_LIVE: begin
                if (!preset && rd_low)
                    state_d = HALF_HELD;
            end
            HALF_HELD: begin
                if (preset)
                    state_d = HALF_LIVE;
                else if (rd_low)
                    state_d = HALF_HELD;
                else if (rd_high)
                    state_d = HALF_LIVE;
            end
            default: state_d = HALF_LIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HALF_LIVE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_low && !preset)
                held_q <= count[CNT_W-1:HALF_W];
        end
    end

    always_comb begin
        upper_view = (state_q == HALF_HELD) ? held_q : count[CNT_W-1:HALF_W];
        rd_data    = '0;
        if (rd_en) begin
            unique case (rd_sel_e'(rd_sel))
                RD_STATUS: rd_data = RD_W'(status);
                RD_LOW:    rd_data = RD_W'(count[HALF_W-1:0]);
                RD_HIGH:   rd_data = RD_W'(upper_view);
                RD_NONE:   rd_data = '0;
                default:   rd_data = '0;
            endcase
        end
    end

    // R4
    hold_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_low && !preset) |=> state_q == HALF_HELD);
    // R4
    hold_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HALF_HELD && rd_high && !rd_low && !preset) |=> state_q == HALF_LIVE);
    // R7
    hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> state_q == HALF_LIVE);
    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == '0);
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
    parameter int PRE_W  = 6,
    parameter int CNT_W  = 32,
    parameter int STAT_W = 16,
    localparam int HALF_W = CNT_W / 2,
    localparam int RD_W   = (STAT_W > HALF_W) ? STAT_W : HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              preset_en,
    input  logic [CNT_W-1:0]  preset_value,
    input  logic              stat_wr_en,
    input  logic [STAT_W-1:0] stat_wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    output logic [RD_W-1:0]   rd_data,
    output logic              tick_irq
);
    logic              carry;
    logic [STAT_W-1:0] status;
    logic [CNT_W-1:0]  count;
    logic              irq_q;

    rtc_status_reg #(.PRE_W(PRE_W), .STAT_W(STAT_W)) u_status (
        .clk(clk), .rst_n(rst_n), .tick(tick), .preset(preset_en),
        .wr_en(stat_wr_en), .wr_data(stat_wr_data),
        .status(status), .carry(carry)
    );

    rtc_seconds #(.CNT_W(CNT_W)) u_seconds (
        .clk(clk), .rst_n(rst_n), .carry(carry), .preset(preset_en),
        .preset_value(preset_value), .count(count)
    );

    rtc_readout #(.CNT_W(CNT_W), .STAT_W(STAT_W), .RD_W(RD_W)) u_readout (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel),
        .preset(preset_en), .count(count), .status(status), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= tick;
    end

    assign tick_irq = irq_q;

    // R5
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> tick_irq);
    // R5
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !tick_irq);
endmodule

// File: tb/rtc_timebase_test.sv
module rtc_timebase_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        preset_en = 1'b0;
    logic [31:0] preset_value = '0;
    logic        stat_wr_en = 1'b0;
    logic [15:0] stat_wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        tick_irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rtc_timebase uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .preset_en(preset_en),
        .preset_value(preset_value), .stat_wr_en(stat_wr_en),
        .stat_wr_data(stat_wr_data), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .tick_irq(tick_irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] val);
        @(negedge clk);
        rd_en = 1'b1;
        rd_sel = sel;
        #1 val = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_tick(input bit chk_irq);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        if (chk_irq) begin
            #1 check("R5 irq after tick", {31'd0, tick_irq}, 32'd1);
            @(negedge clk);
            #1 check("R5 irq one cycle", {31'd0, tick_irq}, 32'd0);
        end
    endtask

    task automatic do_preset(input logic [31:0] v, input bit with_tick);
        @(negedge clk);
        preset_en = 1'b1;
        preset_value = v;
        tick = with_tick;
        @(negedge clk);
        preset_en = 1'b0;
        tick = 1'b0;
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog R1: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 / R9 reset state and idle reads
        #1 check("R8 irq at reset", {31'd0, tick_irq}, 32'd0);
        check("R9 idle data", {16'd0, rd_data}, 32'd0);
        rd(2'd0, v); check("R8 status at reset", {16'd0, v}, 32'd0);
        rd(2'd1, v); check("R8 low at reset", {16'd0, v}, 32'd0);
        rd(2'd2, v); check("R8 high at reset", {16'd0, v}, 32'd0);
        rd(2'd3, v); check("R9 select 3", {16'd0, v}, 32'd0);

        // R1 / R2 sweep across several prescaler wraps
        t = 0;
        for (int i = 0; i < 300; i++) begin
            pulse_tick(i % 37 == 0);
            t++;
            rd(2'd0, v); check("R1 prescaler", {26'd0, v[5:0]}, t % 64);
            rd(2'd1, v); check("R2 seconds", {16'd0, v}, t / 64);
        end

        // R5 quiet while idle, R2 count holds
        repeat (5) begin
            @(negedge clk);
            #1 check("R5 no tick no irq", {31'd0, tick_irq}, 32'd0);
        end
        rd(2'd1, v); check("R2 hold without tick", {16'd0, v}, 300 / 64);

        // R6 status upper bits
        @(negedge clk); stat_wr_en = 1'b1; stat_wr_data = 16'hEAFF;
        @(negedge clk); stat_wr_en = 1'b0;
        rd(2'd0, v); check("R6 write keeps prescaler", {16'd0, v}, {16'd0, 16'hEAC0 | 16'(300 % 64)});
        for (int i = 0; i < 70; i++) pulse_tick(1'b0);
        rd(2'd0, v); check("R6 tick keeps upper", {16'd0, v}, {16'd0, 16'hEAC0 | 16'(370 % 64)});

        // R7 preset clears prescaler, R3 low half
        do_preset(32'h0001FFFF, 1'b0);
        rd(2'd0, v); check("R7 prescaler cleared", {26'd0, v[5:0]}, 32'd0);
        check("R7 upper status kept", {22'd0, v[15:6]}, {22'd0, 10'h3AB});
        rd(2'd1, v); check("R3 low half", {16'd0, v}, 32'h0000FFFF);

        // R4 coherent split read across a 16-bit carry
        for (int i = 0; i < 63; i++) pulse_tick(1'b0);
        rd(2'd1, v); check("R3 low before carry", {16'd0, v}, 32'h0000FFFF);
        pulse_tick(1'b0);
        rd(2'd2, v); check("R4 held upper", {16'd0, v}, 32'h00000001);
        rd(2'd2, v); check("R4 live upper", {16'd0, v}, 32'h00000002);
        rd(2'd1, v); check("R3 low after carry", {16'd0, v}, 32'h00000000);

        // R2 32-bit wrap
        do_preset(32'hFFFFFFFF, 1'b0);
        for (int i = 0; i < 64; i++) pulse_tick(1'b0);
        rd(2'd1, v); check("R2 wrap low", {16'd0, v}, 32'd0);
        rd(2'd2, v); check("R2 wrap high", {16'd0, v}, 32'd0);

        // R7 preset beats simultaneous tick
        for (int i = 0; i < 10; i++) pulse_tick(1'b0);
        do_preset(32'h12345678, 1'b1);
        #1 check("R5 irq with preset tick", {31'd0, tick_irq}, 32'd1);
        rd(2'd0, v); check("R7 preset wins prescaler", {26'd0, v[5:0]}, 32'd0);
        rd(2'd1, v); check("R7 preset low", {16'd0, v}, 32'h00005678);

        // R7 preset drops captured upper half
        do_preset(32'hABCD0000, 1'b0);
        rd(2'd2, v); check("R7 held dropped", {16'd0, v}, 32'h0000ABCD);

        // R9 select 3 after activity
        rd(2'd3, v); check("R9 select 3 late", {16'd0, v}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule